// File: doc/BRIEF.md
# Peripheral interrupt aggregation register block

This block collects the interrupt sources of one peripheral and drives one interrupt line out of it. A 32-bit register port (byte address, write strobe, write data, combinational read data) gives software access to the source status, the enabled-and-active view of those sources, a per-source enable mask and a priority-resolved source index. It also exposes a master gate for the output line and a command register that resets the block and the logic around it.

The status word mixes two kinds of bit. The low `LATCH_N` bits are sticky internal conditions. An event pulse sets them, and software inverts them by writing ones. The `LIVE_N` bits above them follow the level of their source wires in real time and cannot be written. The pending word is status masked by enable and is never stored. The index register names the lowest-numbered pending bit, so bit 0 has the highest priority. A special code reports that nothing is pending.

A write of the key value to the command register clears every stored bit of the block at that edge. It also emits a one-cycle reset pulse toward the rest of the peripheral.

Top module: `irq_hub`

## Requirements
- R1: After `rst_n` is released, with all live sources low, these registers read 0: status (byte offset 0), pending (4), enable (8) and the master gate (28). The index register (24) reads 128, and `irq_out` and `soft_rst_out` are 0.
- R2: Status bits [LATCH_N-1:0] are latched. Status bits [LATCH_N+LIVE_N-1:LATCH_N] equal `src_live` in the same cycle, and higher bits read 0. Writes to status have no effect on the live bits.
- R3: On a status write, each latched bit whose write-data bit is 1 inverts at that clock edge. A latched bit whose write-data bit is 0 keeps its value.
- R4: A high `err_evt[i]` at a clock edge sets latched status bit i. This takes precedence over an inverting write in the same cycle.
- R5: The enable register at offset 8 stores write-data bits [LATCH_N+LIVE_N-1:0], and its upper bits read 0.
- R6: The pending register at offset 4 reads status AND enable, updated in the same cycle. Writes to it have no effect.
- R7: The index register at offset 24 reads the position of the lowest-numbered set pending bit, or 128 when no bit is pending. It follows the inputs in the same cycle.
- R8: The master gate register at offset 28 stores only write-data bit 31, and all its other bits read 0.
- R9: `irq_out` is registered. After each clock edge it equals (gate bit AND any pending bit) as they stood before that edge.
- R10: A write of 0x0000000A to offset 64 clears the enables, the gate bit, the latched status bits and `irq_out` at that edge. `soft_rst_out` is then high for exactly the one following cycle.
- R11: A write of any other value to offset 64 has no effect, and reads of offset 64 return 0.
- R12: Reads of any offset other than 0, 4, 8, 24, 28 return 0, and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | ADDR_W | Byte address of the register access |
| reg_we | input | 1 | Write strobe, captured at the rising edge |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| src_live | input | LIVE_N | Level of each live interrupt source |
| err_evt | input | LATCH_N | Event pulses that set the latched status bits |
| irq_out | output | 1 | Registered interrupt output |
| soft_rst_out | output | 1 | One-cycle reset pulse for the surrounding logic |

## Verification
The live sources are driven with sparse patterns, a pattern that hits the top status bit and the all-low pattern. These cases separate a correct priority index from an off-by-one shift or a highest-bit encoder, and they show the 128 code. The enable mask is set to patterns that overlap the status word only in part. This shows that pending is a true AND and not a copy of either operand. The latched bit is exercised with write-0, write-1 twice and an event together with a write, which separates inversion from set, clear and event precedence. The command register receives both a non-key value and the key, and the bench watches the output line one and two cycles after each gate change to confirm the single register delay.

// File: rtl/irq_hub_pkg.sv
package irq_hub_pkg;
   localparam int REG_W      = 32;
   localparam int ID_W       = 8;
   localparam int OFS_STATUS = 0;
   localparam int OFS_PEND   = 4;
   localparam int OFS_EN     = 8;
   localparam int OFS_ID     = 24;
   localparam int OFS_GATE   = 28;
   localparam int OFS_CMD    = 64;
   localparam int GATE_BIT   = 31;
   localparam int ID_NONE    = 128;
   localparam logic [REG_W-1:0] CMD_KEY = 32'h0000_000A;
   localparam int MIN_ADDR_W = 7;
endpackage

// File: rtl/irq_hub_regs.sv
module irq_hub_regs
   import irq_hub_pkg::*;
#(
   parameter int LATCH_N = 1,
   parameter int SRC_N   = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               soft_clr,
   input  logic               wr_status,
   input  logic               wr_en,
   input  logic               wr_gate,
   input  logic [REG_W-1:0]   wdata,
   input  logic [LATCH_N-1:0] err_evt,
   output logic [LATCH_N-1:0] lat_q,
   output logic [SRC_N-1:0]   en_q,
   output logic               gate_q
);
   for (genvar i = 0; i < LATCH_N; i++) begin : g_latch
      logic bit_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            bit_q <= 1'b0;
         end else if (soft_clr) begin
            bit_q <= 1'b0;
         end else if (err_evt[i]) begin
            bit_q <= 1'b1;
         end else if (wr_status && wdata[i]) begin
            bit_q <= ~bit_q;
         end
      end
      assign lat_q[i] = bit_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q   <= '0;
         gate_q <= 1'b0;
      end else if (soft_clr) begin
         en_q   <= '0;
         gate_q <= 1'b0;
      end else begin
         if (wr_en)   en_q   <= wdata[SRC_N-1:0];
         if (wr_gate) gate_q <= wdata[GATE_BIT];
      end
   end
endmodule

// File: rtl/irq_hub_prio.sv
module irq_hub_prio
   import irq_hub_pkg::*;
#(
   parameter int SRC_N = 16
) (
   input  logic [SRC_N-1:0] pend,
   output logic [ID_W-1:0]  id
);
   always_comb begin
      id = ID_W'(ID_NONE);
      for (int i = SRC_N - 1; i >= 0; i--) begin
         if (pend[i]) id = ID_W'(i);
      end
   end
endmodule

// File: rtl/irq_hub_rstcmd.sv
module irq_hub_rstcmd (
   input  logic clk,
   input  logic rst_n,
   input  logic hit,
   output logic pulse_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pulse_q <= 1'b0;
      else        pulse_q <= hit;
   end
endmodule

// File: rtl/irq_hub.sv
module irq_hub
   import irq_hub_pkg::*;
#(
   parameter int ADDR_W  = 8,
   parameter int LATCH_N = 1,
   parameter int LIVE_N  = 15
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [ADDR_W-1:0]   reg_addr,
   input  logic                reg_we,
   input  logic [REG_W-1:0]    reg_wdata,
   output logic [REG_W-1:0]    reg_rdata,
   input  logic [LIVE_N-1:0]   src_live,
   input  logic [LATCH_N-1:0]  err_evt,
   output logic                irq_out,
   output logic                soft_rst_out
);
   localparam int SRC_N = LATCH_N + LIVE_N;
   localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(OFS_STATUS);
   localparam logic [ADDR_W-1:0] A_PEND   = ADDR_W'(OFS_PEND);
   localparam logic [ADDR_W-1:0] A_EN     = ADDR_W'(OFS_EN);
   localparam logic [ADDR_W-1:0] A_ID     = ADDR_W'(OFS_ID);
   localparam logic [ADDR_W-1:0] A_GATE   = ADDR_W'(OFS_GATE);
   localparam logic [ADDR_W-1:0] A_CMD    = ADDR_W'(OFS_CMD);

   if (ADDR_W < MIN_ADDR_W) begin : g_bad_addr
      $error("irq_hub: ADDR_W too narrow for the command offset");
   end
   if (LATCH_N < 1 || LIVE_N < 1) begin : g_bad_src
      $error("irq_hub: need at least one latched and one live source");
   end
   if (SRC_N > REG_W) begin : g_bad_width
      $error("irq_hub: more sources than register bits");
   end

   logic [LATCH_N-1:0] lat_q;
   logic [SRC_N-1:0]   en_q;
   logic               gate_q;
   logic [SRC_N-1:0]   stat;
   logic [SRC_N-1:0]   pend;
   logic [ID_W-1:0]    id;
   logic               cmd_hit;
   logic               irq_q;

   assign cmd_hit = reg_we && (reg_addr == A_CMD) && (reg_wdata == CMD_KEY);

   irq_hub_regs #(.LATCH_N(LATCH_N), .SRC_N(SRC_N)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .soft_clr  (cmd_hit),
      .wr_status (reg_we && (reg_addr == A_STATUS)),
      .wr_en     (reg_we && (reg_addr == A_EN)),
      .wr_gate   (reg_we && (reg_addr == A_GATE)),
      .wdata     (reg_wdata),
      .err_evt   (err_evt),
      .lat_q     (lat_q),
      .en_q      (en_q),
      .gate_q    (gate_q)
   );

   assign stat = {src_live, lat_q};
   assign pend = stat & en_q;

   irq_hub_prio #(.SRC_N(SRC_N)) u_prio (
      .pend (pend),
      .id   (id)
   );

   irq_hub_rstcmd u_cmd (
      .clk     (clk),
      .rst_n   (rst_n),
      .hit     (cmd_hit),
      .pulse_q (soft_rst_out)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       irq_q <= 1'b0;
      else if (cmd_hit) irq_q <= 1'b0;
      else              irq_q <= gate_q && (|pend);
   end
   assign irq_out = irq_q;

   always_comb begin
      reg_rdata = '0;
      if (reg_addr == A_STATUS)    reg_rdata[SRC_N-1:0] = stat;
      else if (reg_addr == A_PEND) reg_rdata[SRC_N-1:0] = pend;
      else if (reg_addr == A_EN)   reg_rdata[SRC_N-1:0] = en_q;
      else if (reg_addr == A_ID)   reg_rdata[ID_W-1:0]  = id;
      else if (reg_addr == A_GATE) reg_rdata[GATE_BIT]  = gate_q;
   end
endmodule

// File: rtl/irq_hub_chk.sv
module irq_hub_chk
   import irq_hub_pkg::*;
#(
   parameter int ADDR_W  = 8,
   parameter int LATCH_N = 1,
   parameter int LIVE_N  = 15
) (
   input logic                clk,
   input logic                rst_n,
   input logic [ADDR_W-1:0]   reg_addr,
   input logic                reg_we,
   input logic [REG_W-1:0]    reg_wdata,
   input logic [REG_W-1:0]    reg_rdata,
   input logic [LIVE_N-1:0]   src_live,
   input logic [LATCH_N-1:0]  err_evt,
   input logic                irq_out,
   input logic                soft_rst_out,
   input logic [LATCH_N-1:0]  lat_q,
   input logic [LATCH_N+LIVE_N-1:0] en_q,
   input logic                gate_q
);
   localparam int SRC_N = LATCH_N + LIVE_N;
   logic key_wr;
   logic cmd_wr;
   assign cmd_wr = reg_we && (reg_addr == ADDR_W'(OFS_CMD));
   assign key_wr = cmd_wr && (reg_wdata == CMD_KEY);

   a_r9_gate_blocks: assert property (@(posedge clk) disable iff (!rst_n)
      !gate_q |=> !irq_out);
   a_r10_pulse_cause: assert property (@(posedge clk) disable iff (!rst_n)
      soft_rst_out |-> $past(key_wr));
   a_r10_clear_all: assert property (@(posedge clk) disable iff (!rst_n)
      key_wr |=> (en_q == '0) && !gate_q && (lat_q == '0) && !irq_out);
   a_r11_other_value: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_wr && !key_wr) |=> !soft_rst_out);
   a_r3_toggle: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we && reg_addr == ADDR_W'(OFS_STATUS) && reg_wdata[0] && !err_evt[0])
      |=> (lat_q[0] != $past(lat_q[0])));
   a_r4_event_sets: assert property (@(posedge clk) disable iff (!rst_n)
      (err_evt[0] && !key_wr) |=> lat_q[0]);
   a_r2_live_view: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_addr == ADDR_W'(OFS_STATUS)) |-> (reg_rdata[SRC_N-1:LATCH_N] == src_live));
   a_r7_id_range: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_addr == ADDR_W'(OFS_ID)) |-> (reg_rdata == ID_NONE || reg_rdata < SRC_N));
   a_r12_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_addr == ADDR_W'(12)) |-> (reg_rdata == '0));
endmodule

bind irq_hub irq_hub_chk #(.ADDR_W(ADDR_W), .LATCH_N(LATCH_N), .LIVE_N(LIVE_N)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .reg_addr     (reg_addr),
   .reg_we       (reg_we),
   .reg_wdata    (reg_wdata),
   .reg_rdata    (reg_rdata),
   .src_live     (src_live),
   .err_evt      (err_evt),
   .irq_out      (irq_out),
   .soft_rst_out (soft_rst_out),
   .lat_q        (lat_q),
   .en_q         (en_q),
   .gate_q       (gate_q)
);

// File: tb/irq_hub_tb_top.sv
`timescale 1ns/1ps
module irq_hub_tb_top;
   localparam int ADDR_W = 8;
   localparam int LATCH_N = 1;
   localparam int LIVE_N = 15;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [ADDR_W-1:0] reg_addr = '0;
   logic              reg_we = 1'b0;
   logic [31:0]       reg_wdata = '0;
   logic [31:0]       reg_rdata;
   logic [LIVE_N-1:0] src_live = '0;
   logic [LATCH_N-1:0] err_evt = '0;
   logic              irq_out;
   logic              soft_rst_out;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   int          kind_q[$];
   logic [31:0] exp_q[$];
   string       tag_q[$];

   always #2 clk = ~clk;

   irq_hub #(.ADDR_W(ADDR_W), .LATCH_N(LATCH_N), .LIVE_N(LIVE_N)) dut_i (
      .clk          (clk),
      .rst_n        (rst_n),
      .reg_addr     (reg_addr),
      .reg_we       (reg_we),
      .reg_wdata    (reg_wdata),
      .reg_rdata    (reg_rdata),
      .src_live     (src_live),
      .err_evt      (err_evt),
      .irq_out      (irq_out),
      .soft_rst_out (soft_rst_out)
   );

   // monitor: kind 0 = read data, 1 = irq_out, 2 = soft_rst_out
   always @(negedge clk) begin
      while (kind_q.size() > 0) begin
         int k;
         logic [31:0] e;
         logic [31:0] a;
         string t;
         k = kind_q.pop_front();
         e = exp_q.pop_front();
         t = tag_q.pop_front();
         a = (k == 0) ? reg_rdata : (k == 1) ? {31'b0, irq_out} : {31'b0, soft_rst_out};
         checks++;
         if (a !== e) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", t, a, e);
         end
      end
   end

   task automatic push(input int k, input logic [31:0] e, input string t);
      kind_q.push_back(k);
      exp_q.push_back(e);
      tag_q.push_back(t);
   endtask

   task automatic step();
      @(posedge clk); #1;
   endtask

   task automatic wr(input int a, input logic [31:0] d);
      step();
      reg_we = 1'b1; reg_addr = ADDR_W'(a); reg_wdata = d;
      step();
      reg_we = 1'b0;
   endtask

   task automatic rd(input int a, input logic [31:0] e, input string t);
      step();
      reg_we = 1'b0; reg_addr = ADDR_W'(a);
      push(0, e, t);
      @(negedge clk); #1;
   endtask

   task automatic sig(input int k, input logic e, input string t);
      push(k, {31'b0, e}, t);
      @(negedge clk); #1;
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      if (!done) begin
         failures++;
         checks++;
         $display("FAIL watchdog expired actual=1 expected=0");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      // R1 reset state
      rd(0, 32'h0, "R1 status");
      rd(8, 32'h0, "R1 enable");
      rd(28, 32'h0, "R1 gate");
      rd(4, 32'h0, "R1 pending");
      rd(24, 32'd128, "R1 index");
      sig(1, 1'b0, "R1 irq_out");
      sig(2, 1'b0, "R1 soft_rst_out");
      // R2 live view, writes ignored
      step(); src_live = 15'h0005;
      rd(0, 32'h0000_000A, "R2 live bits");
      wr(0, 32'hFFFF_FFFE);
      rd(0, 32'h0000_000A, "R2 write ignored");
      // R3 inversion
      wr(0, 32'h1);
      rd(0, 32'h0000_000B, "R3 set by toggle");
      wr(0, 32'h1);
      rd(0, 32'h0000_000A, "R3 clear by toggle");
      wr(0, 32'h0);
      rd(0, 32'h0000_000A, "R3 zero keeps");
      // R4 event
      step(); err_evt = 1'b1;
      step(); err_evt = 1'b0;
      rd(0, 32'h0000_000B, "R4 event sets");
      step(); err_evt = 1'b1; reg_we = 1'b1; reg_addr = 8'd0; reg_wdata = 32'h1;
      step(); err_evt = 1'b0; reg_we = 1'b0;
      rd(0, 32'h0000_000B, "R4 event beats toggle");
      wr(0, 32'h1);
      // R5 enable
      wr(8, 32'hFFFF_FFFF);
      rd(8, 32'h0000_FFFF, "R5 enable width");
      wr(8, 32'h0000_0088);
      rd(8, 32'h0000_0088, "R5 enable value");
      // R6 pending
      step(); src_live = 15'h0045;
      rd(4, 32'h0000_0088, "R6 pending and");
      wr(4, 32'hFFFF_FFFF);
      rd(4, 32'h0000_0088, "R6 pending write ignored");
      rd(8, 32'h0000_0088, "R6 enable untouched");
      // R7 index
      rd(24, 32'd3, "R7 lowest pending");
      wr(0, 32'h1);
      wr(8, 32'h0000_0089);
      rd(24, 32'd0, "R7 bit0 wins");
      wr(0, 32'h1);
      rd(24, 32'd3, "R7 after clear");
      step(); src_live = 15'h4000;
      wr(8, 32'h0000_8000);
      rd(24, 32'd15, "R7 top bit");
      step(); src_live = 15'h0000;
      rd(24, 32'd128, "R7 none");
      // R8 gate
      wr(28, 32'hFFFF_FFFF);
      rd(28, 32'h8000_0000, "R8 only bit31");
      wr(28, 32'h7FFF_FFFF);
      rd(28, 32'h0000_0000, "R8 bit31 clear");
      // R9 registered output
      step(); src_live = 15'h4000;
      sig(1, 1'b0, "R9 gate off");
      wr(28, 32'h8000_0000);
      sig(1, 1'b0, "R9 one cycle delay");
      step();
      sig(1, 1'b1, "R9 asserted");
      step(); src_live = 15'h0000;
      sig(1, 1'b1, "R9 fall delayed");
      step();
      sig(1, 1'b0, "R9 deasserted");
      // R11 non-key
      step(); src_live = 15'h4000;
      wr(0, 32'h1);
      wr(64, 32'h0000_0005);
      sig(2, 1'b0, "R11 no pulse");
      rd(8, 32'h0000_8000, "R11 enable kept");
      rd(28, 32'h8000_0000, "R11 gate kept");
      rd(64, 32'h0, "R11 reads zero");
      sig(1, 1'b1, "R11 irq kept");
      // R10 key
      wr(64, 32'h0000_000A);
      push(1, 32'h0, "R10 irq cleared");
      sig(2, 1'b1, "R10 pulse high");
      step();
      sig(2, 1'b0, "R10 pulse one cycle");
      rd(8, 32'h0, "R10 enable cleared");
      rd(28, 32'h0, "R10 gate cleared");
      rd(0, 32'h0000_8000, "R10 latched cleared");
      // R12 reserved
      wr(8, 32'h3);
      wr(12, 32'hFFFF_FFFF);
      rd(12, 32'h0, "R12 reserved read");
      rd(32, 32'h0, "R12 reserved read 32");
      rd(8, 32'h3, "R12 write ignored");
      step();
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule